// File: doc/BRIEF.md
# Serial-armed logic analyzer capture core

This core watches a small group of probe signals inside a design and records them for later inspection over a serial link. Each clock cycle the probes are packed into one sample word. A set of trigger terms is evaluated on that word, and the trigger is the OR of the terms. A host arms the core by sending one command byte through a UART receiver. The core then waits for the trigger. When the trigger fires, it stores a fixed number of consecutive samples in an on-chip buffer. It then sends the whole buffer back through a UART transmitter, one byte at a time.

Each trigger term is an AND of chosen sample bits, and each chosen bit may be inverted. Each term is described by a care mask and a polarity mask over the sample word. A sample wider than one byte is sent as several bytes, least significant byte first, and the spare upper bits are zero. The UART line coding sits outside the core. The core sees a received-byte strobe and a valid/ready byte handshake toward the transmitter.

Top module: `la_capture_top`

## Requirements
- R1: After reset the core is idle and `tx_valid_o` is low. No byte is offered until a capture has completed.
- R2: The sample word is `{probe_d_i, probe_c_i, probe_b_i, probe_a_i}`. Probe A occupies bit 0 upward, and each later probe sits directly above the one before it.
- R3: Trigger term t fires when every sample bit set in its care mask equals the matching bit of its polarity mask. A term whose care mask is empty never fires. The trigger is the OR of all terms, so a sample that matches only some bits of a term does not fire that term.
- R4: While idle, a cycle with `rx_valid_i` high and `rx_data_i` equal to 0x30 arms the core. The trigger is evaluated from the following cycle onward, and never in the command cycle itself.
- R5: A received byte other than 0x30 has no effect in any state. A 0x30 that arrives while the core is armed, capturing or reading out also has no effect.
- R6: The sample of the cycle in which the trigger fires is stored at buffer address 0. The samples of the next DEPTH-1 cycles follow at consecutive addresses, and capture then stops.
- R7: Readout starts in the cycle after the last sample is written. `tx_valid_o` is high throughout readout. A byte is accepted on a cycle with `tx_valid_o` and `tx_ready_i` both high. While a byte is not accepted, `tx_data_o` holds its value. Samples are sent in address order, and exactly DEPTH×NB bytes are sent, where NB = ceil(SW/8).
- R8: Within a sample, byte 0 (bits 7:0) is sent first. In the last byte, bit positions above the sample width are driven to zero.
- R9: After the last byte is accepted, the core returns to idle with `tx_valid_o` low, and a new 0x30 starts a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_a_i | input | W_A | First probe, least significant in the sample |
| probe_b_i | input | W_B | Second probe |
| probe_c_i | input | W_C | Third probe |
| probe_d_i | input | W_D | Fourth probe, most significant in the sample |
| rx_valid_i | input | 1 | One-cycle strobe marking a received byte |
| rx_data_i | input | 8 | Received byte |
| tx_ready_i | input | 1 | Transmitter can accept a byte this cycle |
| tx_valid_o | output | 1 | A readout byte is offered |
| tx_data_o | output | 8 | Readout byte |

## Verification
A sequencer stuck in the wrong state shows up at once at the transmit port. A spurious arm or an early trigger shifts the whole dump by one or more samples, and the first offered byte is then wrong. A wrong write address corrupts a specific byte of the dump. A wrong byte or sample counter repeats or skips bytes and changes the total byte count. The bench runs a reference model cycle by cycle and compares `tx_valid_o` and `tx_data_o` on every clock. Most such faults therefore fail in the first readout cycle they affect, and a premature or missing return to idle fails in the cycle it occurs.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_READOUT = 2'd3
    } la_state_e;

    localparam logic [7:0] ARM_CMD = 8'h30;

endpackage

// File: rtl/la_probe_pack.sv
module la_probe_pack #(
    parameter int W_A = 1,
    parameter int W_B = 1,
    parameter int W_C = 1,
    parameter int W_D = 3,
    localparam int SW = W_A + W_B + W_C + W_D
) (
    input  logic [W_A-1:0] probe_a_i,
    input  logic [W_B-1:0] probe_b_i,
    input  logic [W_C-1:0] probe_c_i,
    input  logic [W_D-1:0] probe_d_i,
    output logic [SW-1:0]  sample_o
);
    localparam int OFF_B = W_A;
    localparam int OFF_C = OFF_B + W_B;
    localparam int OFF_D = OFF_C + W_C;

    always_comb begin
        sample_o = '0;
        sample_o[W_A-1:0]       = probe_a_i;
        sample_o[OFF_B +: W_B]  = probe_b_i;
        sample_o[OFF_C +: W_C]  = probe_c_i;
        sample_o[OFF_D +: W_D]  = probe_d_i;
    end

endmodule

// File: rtl/la_trigger.sv
module la_trigger #(
    parameter int SW = 6,
    parameter int NT = 2,
    parameter logic [NT*SW-1:0] TERM_CARE = {6'h21, 6'h07},
    parameter logic [NT*SW-1:0] TERM_POL  = {6'h20, 6'h03}
) (
    input  logic [SW-1:0] sample_i,
    output logic          fire_o
);
    logic [NT-1:0] term_hit;

    for (genvar t = 0; t < NT; t++) begin : g_term
        localparam logic [SW-1:0] CARE = TERM_CARE[t*SW +: SW];
        localparam logic [SW-1:0] POL  = TERM_POL[t*SW +: SW];
        logic [SW-1:0] mismatch;
        always_comb begin
            mismatch    = (sample_i ^ POL) & CARE;
            term_hit[t] = (CARE != '0) && (mismatch == '0);
        end
    end

    assign fire_o = |term_hit;

endmodule

// File: rtl/la_sample_buf.sv
module la_sample_buf #(
    parameter int SW    = 6,
    parameter int DEPTH = 4096,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [SW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [SW-1:0] rd_data_o
);
    logic [SW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i)); // R6

endmodule

// File: rtl/la_sequencer.sv
module la_sequencer
    import la_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int NB    = 1,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid_i,
    input  logic [7:0]    rx_data_i,
    input  logic          fire_i,
    input  logic          tx_ready_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW-1:0] rd_addr_o,
    output logic [BW-1:0] byte_sel_o,
    output logic          tx_valid_o
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [BW-1:0] LAST_BYTE = BW'(NB - 1);

    typedef struct packed {
        la_state_e     st;
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [BW-1:0] bsel;
    } seq_t;

    seq_t seq_d, seq_q;
    logic arm_cmd;

    assign arm_cmd = rx_valid_i && (rx_data_i == ARM_CMD);

    always_comb begin
        seq_d   = seq_q;
        wr_en_o = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                seq_d.wr = '0;
                if (arm_cmd) begin
                    seq_d.st = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (fire_i) begin
                    wr_en_o  = 1'b1;
                    seq_d.wr = seq_q.wr + AW'(1);
                    seq_d.st = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                wr_en_o = 1'b1;
                if (seq_q.wr == LAST_ADDR) begin
                    seq_d.st   = ST_READOUT;
                    seq_d.rd   = '0;
                    seq_d.bsel = '0;
                end else begin
                    seq_d.wr = seq_q.wr + AW'(1);
                end
            end
            ST_READOUT: begin
                if (tx_ready_i) begin
                    if (seq_q.bsel == LAST_BYTE) begin
                        seq_d.bsel = '0;
                        if (seq_q.rd == LAST_ADDR) begin
                            seq_d.st = ST_IDLE;
                        end else begin
                            seq_d.rd = seq_q.rd + AW'(1);
                        end
                    end else begin
                        seq_d.bsel = seq_q.bsel + BW'(1);
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, wr: '0, rd: '0, bsel: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wr_addr_o  = seq_q.wr;
    assign rd_addr_o  = seq_q.rd;
    assign byte_sel_o = seq_q.bsel;
    assign tx_valid_o = (seq_q.st == ST_READOUT);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && !arm_cmd) |=> seq_q.st == ST_IDLE); // R5
    AST_ARM_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && arm_cmd) |=> seq_q.st == ST_ARMED); // R4
    AST_ARMED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_ARMED && !fire_i) |=> seq_q.st == ST_ARMED); // R5
    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_ARMED && fire_i) |=> (seq_q.st == ST_CAPTURE && seq_q.wr == AW'(1))); // R6
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.st == ST_CAPTURE |-> seq_q.wr != '0); // R6
    AST_RO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid_o) |-> $past(seq_q.st) == ST_CAPTURE); // R7

endmodule

// File: rtl/la_capture_top.sv
module la_capture_top #(
    parameter int W_A   = 1,
    parameter int W_B   = 1,
    parameter int W_C   = 1,
    parameter int W_D   = 3,
    parameter int DEPTH = 4096,
    parameter int NT    = 2,
    localparam int SW   = W_A + W_B + W_C + W_D,
    parameter logic [NT*SW-1:0] TERM_CARE = {6'h21, 6'h07},
    parameter logic [NT*SW-1:0] TERM_POL  = {6'h20, 6'h03}
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W_A-1:0] probe_a_i,
    input  logic [W_B-1:0] probe_b_i,
    input  logic [W_C-1:0] probe_c_i,
    input  logic [W_D-1:0] probe_d_i,
    input  logic           rx_valid_i,
    input  logic [7:0]     rx_data_i,
    input  logic           tx_ready_i,
    output logic           tx_valid_o,
    output logic [7:0]     tx_data_o
);
    localparam int NB = (SW + 7) / 8;
    localparam int AW = $clog2(DEPTH);
    localparam int BW = (NB > 1) ? $clog2(NB) : 1;

    logic [SW-1:0]   sample;
    logic [SW-1:0]   rd_data;
    logic            fire;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [AW-1:0]   rd_addr;
    logic [BW-1:0]   byte_sel;
    logic [NB*8-1:0] padded;

    la_probe_pack #(.W_A(W_A), .W_B(W_B), .W_C(W_C), .W_D(W_D)) u_pack (
        .probe_a_i (probe_a_i),
        .probe_b_i (probe_b_i),
        .probe_c_i (probe_c_i),
        .probe_d_i (probe_d_i),
        .sample_o  (sample)
    );

    la_trigger #(.SW(SW), .NT(NT), .TERM_CARE(TERM_CARE), .TERM_POL(TERM_POL)) u_trig (
        .sample_i (sample),
        .fire_o   (fire)
    );

    la_sample_buf #(.SW(SW), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (sample),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    la_sequencer #(.DEPTH(DEPTH), .NB(NB)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .fire_i     (fire),
        .tx_ready_i (tx_ready_i),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .rd_addr_o  (rd_addr),
        .byte_sel_o (byte_sel),
        .tx_valid_o (tx_valid_o)
    );

    always_comb begin
        padded = '0;
        padded[SW-1:0] = rd_data;
    end

    assign tx_data_o = padded[8*byte_sel +: 8];

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid_o && !wr_en && !fire && !(rx_valid_i && rx_data_i == la_pkg::ARM_CMD))
        |=> !tx_valid_o); // R5

endmodule

// File: tb/la_capture_top_test.sv
module la_capture_top_test;
    localparam int DEPTH = 16;
    localparam int W_D   = 8;
    localparam int SW    = 3 + W_D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic       pa = 1'b0, pb = 1'b0, pc = 1'b0;
    logic [7:0] pd = 8'h00;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_ready = 1'b1;
    logic       tx_valid;
    logic [7:0] tx_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ready_mode = 0;
    bit done = 0;
    string cur_req = "R1";

    int m_state = 0;
    int m_idx = 0;
    int m_bi = 0;
    int cap_q[$];
    int got_q[$];

    la_capture_top #(
        .W_A(1), .W_B(1), .W_C(1), .W_D(W_D), .DEPTH(DEPTH), .NT(2),
        .TERM_CARE({11'h401, 11'h007}),
        .TERM_POL ({11'h400, 11'h003})
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .probe_a_i(pa), .probe_b_i(pb), .probe_c_i(pc), .probe_d_i(pd),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .tx_ready_i(tx_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data)
    );

    always #4 clk = ~clk;

    function automatic int sample_val();
        return int'(pa) + 2 * int'(pb) + 4 * int'(pc) + 8 * int'(pd);
    endfunction

    function automatic bit trig_model();
        return (pa && pb && !pc) || (pd[7] && !pa);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_state = 0;
        end else begin
            case (m_state)
                0: if (rx_valid && rx_data == 8'h30) m_state = 1;
                1: if (trig_model()) begin
                       cap_q.delete();
                       cap_q.push_back(sample_val());
                       m_state = 2;
                   end
                2: begin
                       cap_q.push_back(sample_val());
                       if (cap_q.size() == DEPTH) begin
                           m_state = 3; m_idx = 0; m_bi = 0;
                       end
                   end
                default: if (tx_ready) begin
                       if (m_bi == 1) begin
                           m_bi = 0; m_idx++;
                           if (m_idx == DEPTH) m_state = 0;
                       end else m_bi = 1;
                   end
            endcase
        end
    end

    // per-cycle compare, ready driving, byte collection
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, int'(tx_valid), (m_state == 3) ? 1 : 0);
            if (m_state == 3 && tx_valid)
                check(cur_req, int'(tx_data), (cap_q[m_idx] >> (8 * m_bi)) & 255);
        end
        case (ready_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = cyc[0];
            default: tx_ready = (cyc % 3) == 0;
        endcase
        if (rst_n && tx_valid && tx_ready) got_q.push_back(int'(tx_data));
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic setp(input logic a, input logic b, input logic c, input logic [7:0] d);
        pa = a; pb = b; pc = c; pd = d;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && m_state != 0; i++) @(negedge clk);
    endtask

    task automatic capture_noise(input int seed);
        for (int i = 0; i < DEPTH + 2; i++) begin
            @(negedge clk);
            setp(1'(i + seed), 1'(i >> 1), 1'(i >> 2), 8'(i * 37 + seed));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(tx_valid), 0);

        // R5: foreign bytes while idle, trigger pattern present
        cur_req = "R5";
        setp(1, 1, 0, 8'h00);
        send(8'h31); send(8'h00); send(8'hFF);
        repeat (8) @(negedge clk);
        check("R5", int'(tx_valid), 0);
        check("R5", got_q.size(), 0);

        // run 1: partial match must not fire (R3), then term 0 fires
        cur_req = "R3";
        setp(1, 1, 1, 8'h00);
        send(8'h30);
        repeat (4) @(negedge clk);
        send(8'h30);               // R5: re-arm while armed ignored
        setp(0, 1, 0, 8'h7F);
        repeat (3) @(negedge clk);
        check("R3", int'(tx_valid), 0);
        got_q.delete();
        cur_req = "R6";
        setp(1, 1, 0, 8'hA5);
        capture_noise(5);
        cur_req = "R7";
        wait_idle();
        check("R7", got_q.size(), 2 * DEPTH);
        check("R6", got_q[0], 8'h2B);
        check("R2", got_q[1], 8'h05);
        check("R8", got_q[3] >> 3, 0);

        // run 2: term 1 fires, ready toggles, stray bytes mid-run
        cur_req = "R9";
        @(negedge clk);
        check("R9", int'(tx_valid), 0);
        ready_mode = 1;
        got_q.delete();
        setp(1, 0, 0, 8'h80);
        send(8'h30);
        repeat (2) @(negedge clk);
        cur_req = "R3";
        setp(0, 1, 1, 8'h80);
        @(negedge clk);
        setp(0, 0, 0, 8'h01);
        rx_valid = 1'b1; rx_data = 8'h12;
        @(negedge clk); rx_valid = 1'b0;
        capture_noise(9);
        cur_req = "R5";
        send(8'h30); send(8'h55);
        cur_req = "R7";
        wait_idle();
        check("R7", got_q.size(), 2 * DEPTH);
        check("R3", got_q[0], 8'h06);
        check("R8", got_q[1], 8'h04);

        // run 3: trigger present in the command cycle (R4)
        cur_req = "R4";
        ready_mode = 2;
        got_q.delete();
        setp(1, 1, 0, 8'h3C);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h30;
        @(negedge clk);
        rx_valid = 1'b0; setp(1, 1, 0, 8'h11);
        capture_noise(3);
        wait_idle();
        check("R4", got_q[0], 8'h8B);
        check("R4", got_q[1], 8'h00);
        check("R9", got_q.size(), 2 * DEPTH);
        cur_req = "R9";
        send(8'h31);
        repeat (5) @(negedge clk);
        check("R9", int'(tx_valid), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule